// File: doc/BRIEF.md
# Local Bus Interrupt Vector Controller

This block gathers up to sixteen level-sensitive interrupt request lines, qualifies them with a software-written enable mask and drives one combined interrupt line to the processor. The handler reads a source register that holds a ready-made vector for the lowest-numbered request that is both raised and enabled, so no bit scan is needed in software. In the intended system, line 0 is the parallel port, then floppy, sound, video, network, SCSI, keyboard, mouse and the two serial ports on lines 8 and 9. Lines 10 to 15 are spare.

The registers are natively 16 bits wide. Processor accesses of 8, 16 and 32 bits arrive on a valid/ready request channel and are turned into one or two internal halfword operations. A byte write becomes a read-merge-write of the halfword that holds it. A 32-bit access becomes two halfword operations. The request channel exerts back-pressure: `req_ready` is high only when no access is in flight. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The response has no back-pressure: `rsp_valid` is a one-cycle strobe that the requester must capture.

Top module: `lbic_top`

## Requirements
- R1: The request lines are sampled into a status register on every clock. The pending set is the status AND the low bits of the mask. `irq_out` is registered and is high exactly when the request lines sampled at the previous edge, ANDed with the mask, are nonzero. It follows a request change one clock later and a mask write at the same edge that updates the mask.
- R2: A halfword read at offset 0x000 returns `(n+1)<<2`, where n is the lowest-numbered pending source. It returns 0 when nothing is pending, so source 0 gives 4 and source 15 gives 64.
- R3: Offset 0x002 holds the 16-bit enable mask. All 16 bits are writable and read back unchanged.
- R4: `req_size` 0 is a byte access. A byte read returns the aligned halfword's bits [7:0] when address bit 0 is 0 and bits [15:8] when it is 1. The byte is zero-extended in `rsp_rdata[7:0]`.
- R5: A byte write takes its data from `req_wdata[7:0]` for either lane. It replaces only the addressed byte of the aligned halfword and writes the merged halfword back, so the other byte keeps its value.
- R6: `req_size` 2 or 3 is a 32-bit access. Its low half goes to the aligned address and its high half goes to that address plus 2, wrapping within 12 bits. Read data is `{high, low}`. Write data bits [15:0] go to the low half and bits [31:16] go to the high half, in that order.
- R7: Only address bits [11:0] are decoded, and address bit 0 is ignored for halfword operations. Reads of any offset other than 0x000 and 0x002 return 0. Writes to those offsets and to 0x000 change nothing.
- R8: After reset the mask and status are zero, `irq_out` and `rsp_valid` are low, and `req_ready` is high.
- R9: For byte and halfword accesses, `rsp_valid` is high in the second cycle after the accepting edge. For 32-bit accesses it is high in the third. `req_ready` stays low from acceptance until the final operation is done. `rsp_rdata` is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Level interrupt request lines |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | ADDR_W | Byte address, low 12 bits decoded |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data, right-aligned |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
The bench goes after the vector edges: no pending source, source 0, source 15, and several raised lines of which only some are enabled. An encoder that scanned from the wrong end, or that ignored the mask, would return the wrong vector here. Byte writes to each mask lane expose an adapter that skipped the merge, which would clear the other byte. A 32-bit write at 0x000 and one at 0xFFE check both the order of the two halves and the 12-bit wrap of the second half; a design that swapped the halves would load the mask from the wrong word half. An access with high address bits set, reads of unmapped offsets and writes to them catch a decoder that looked at too many bits. The checks on response latency and `req_ready` catch a sequencer that dropped the second phase of a 32-bit access.

// File: rtl/lbic_pkg.sv
package lbic_pkg;
  localparam int REG_W  = 16;
  localparam int OFFS_W = 12;
  localparam logic [OFFS_W-1:0] OFF_VEC  = 12'h000;
  localparam logic [OFFS_W-1:0] OFF_MASK = 12'h002;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } seq_state_e;

  // Replace one byte lane of a halfword.
  function automatic logic [REG_W-1:0] lane_merge(input logic [REG_W-1:0] old_hw,
                                                  input logic [7:0] nbyte,
                                                  input logic hi_lane);
    return hi_lane ? {nbyte, old_hw[7:0]} : {old_hw[15:8], nbyte};
  endfunction
endpackage

// File: rtl/lbic_vec_enc.sv
module lbic_vec_enc #(
  parameter int NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0]          pend,
  output logic [lbic_pkg::REG_W-1:0]  vec
);
  // Lowest set bit wins: scan from the top so the last hit is the lowest.
  always_comb begin
    vec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) vec = lbic_pkg::REG_W'((i + 1) << 2);
    end
  end
endmodule

// File: rtl/lbic_regs.sv
module lbic_regs #(
  parameter int NUM_SRC = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_SRC-1:0]                  irq_req,
  input  logic [lbic_pkg::OFFS_W-1:0]         hw_addr,
  input  logic                                hw_we,
  input  logic [lbic_pkg::REG_W-1:0]          hw_wdata,
  output logic [lbic_pkg::REG_W-1:0]          hw_rdata,
  output logic [lbic_pkg::REG_W-1:0]          mask_q,
  output logic [lbic_pkg::REG_W-1:0]          stat_q,
  output logic                                irq_out
);
  import lbic_pkg::*;

  logic [NUM_SRC-1:0] stat_raw;
  logic [REG_W-1:0]   mask_nxt;
  logic [REG_W-1:0]   vec;
  logic               mask_hit;

  assign mask_hit = hw_we && (hw_addr == OFF_MASK);
  assign mask_nxt = mask_hit ? hw_wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_raw <= '0;
      mask_q   <= '0;
      irq_out  <= 1'b0;
    end else begin
      stat_raw <= irq_req;
      mask_q   <= mask_nxt;
      irq_out  <= |(irq_req & mask_nxt[NUM_SRC-1:0]);
    end
  end

  generate
    if (NUM_SRC < REG_W) begin : g_pad
      assign stat_q = {{(REG_W-NUM_SRC){1'b0}}, stat_raw};
    end else begin : g_full
      assign stat_q = stat_raw;
    end
  endgenerate

  lbic_vec_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .pend (stat_raw & mask_q[NUM_SRC-1:0]),
    .vec  (vec)
  );

  always_comb begin
    case (hw_addr)
      OFF_VEC:  hw_rdata = vec;
      OFF_MASK: hw_rdata = mask_q;
      default:  hw_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lbic_access_seq.sv
module lbic_access_seq #(
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [1:0]                   req_size,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [31:0]                  req_wdata,
  output logic                         rsp_valid,
  output logic [31:0]                  rsp_rdata,
  output logic [lbic_pkg::OFFS_W-1:0]  hw_addr,
  output logic                         hw_we,
  output logic [lbic_pkg::REG_W-1:0]   hw_wdata,
  input  logic [lbic_pkg::REG_W-1:0]   hw_rdata
);
  import lbic_pkg::*;

  seq_state_e        state_q;
  logic [OFFS_W-1:0] addr_q;
  logic              wr_q;
  acc_size_e         size_q;
  logic [31:0]       wdata_q;
  logic [REG_W-1:0]  lo_q;
  logic [OFFS_W-1:0] base_addr;
  logic              is_word;

  assign req_ready = (state_q == ST_IDLE);
  assign base_addr = {addr_q[OFFS_W-1:1], 1'b0};
  assign is_word   = size_q[1];

  always_comb begin
    hw_addr  = base_addr;
    hw_we    = 1'b0;
    hw_wdata = wdata_q[15:0];
    case (state_q)
      ST_LO: begin
        hw_we = wr_q;
        if (size_q == SZ_BYTE) hw_wdata = lane_merge(hw_rdata, wdata_q[7:0], addr_q[0]);
      end
      ST_HI: begin
        hw_addr  = base_addr + OFFS_W'(2);
        hw_we    = wr_q;
        hw_wdata = wdata_q[31:16];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      size_q    <= SZ_BYTE;
      wdata_q   <= '0;
      lo_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr[OFFS_W-1:0];
            wr_q    <= req_write;
            size_q  <= acc_size_e'(req_size);
            wdata_q <= req_wdata;
            state_q <= ST_LO;
          end
        end
        ST_LO: begin
          if (is_word) begin
            lo_q    <= hw_rdata;
            state_q <= ST_HI;
          end else begin
            state_q   <= ST_IDLE;
            rsp_valid <= 1'b1;
            if (wr_q)                    rsp_rdata <= '0;
            else if (size_q == SZ_BYTE)  rsp_rdata <= {24'd0, addr_q[0] ? hw_rdata[15:8] : hw_rdata[7:0]};
            else                         rsp_rdata <= {16'd0, hw_rdata};
          end
        end
        ST_HI: begin
          state_q   <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= wr_q ? 32'd0 : {hw_rdata, lo_q};
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbic_top.sv
module lbic_top #(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               irq_out
);
  import lbic_pkg::*;

  logic [OFFS_W-1:0] hw_addr;
  logic              hw_we;
  logic [REG_W-1:0]  hw_wdata;
  logic [REG_W-1:0]  hw_rdata;
  logic [REG_W-1:0]  mask_q;
  logic [REG_W-1:0]  stat_q;

  lbic_access_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .hw_addr   (hw_addr),
    .hw_we     (hw_we),
    .hw_wdata  (hw_wdata),
    .hw_rdata  (hw_rdata)
  );

  lbic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .hw_addr  (hw_addr),
    .hw_we    (hw_we),
    .hw_wdata (hw_wdata),
    .hw_rdata (hw_rdata),
    .mask_q   (mask_q),
    .stat_q   (stat_q),
    .irq_out  (irq_out)
  );
endmodule

// File: rtl/lbic_checker.sv
module lbic_checker #(
  parameter int NUM_SRC = 16
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_SRC-1:0]                irq_req,
  input logic                              irq_out,
  input logic                              req_valid,
  input logic                              req_ready,
  input logic [1:0]                        req_size,
  input logic                              rsp_valid,
  input logic [lbic_pkg::REG_W-1:0]        mask_q,
  input logic                              hw_we,
  input logic [lbic_pkg::OFFS_W-1:0]       hw_addr,
  input logic [lbic_pkg::REG_W-1:0]        hw_wdata
);
  logic rst_hist;
  always_ff @(posedge clk) rst_hist <= !rst_n;

  // R8: held reset leaves outputs and mask cleared
  always @(posedge clk) begin
    if (!rst_n && rst_hist) begin
      p_reset_clear_r8: assert (!irq_out && !rsp_valid && mask_q == '0 && req_ready);
    end
  end

  // R1: combined output tracks previous request sample and current mask
  p_irq_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_out == |($past(irq_req) & mask_q[NUM_SRC-1:0])));

  // R3: halfword write to the mask offset lands in the mask
  p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we && hw_addr == lbic_pkg::OFF_MASK) |=> (mask_q == $past(hw_wdata)));

  // R9: byte/halfword response two cycles after acceptance
  p_single_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_size[1]) |-> ##2 rsp_valid);

  // R6: 32-bit access holds off new requests for two cycles, then responds
  p_word_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size[1]) |=> !req_ready ##1 (!req_ready && !rsp_valid) ##1 rsp_valid);
endmodule

bind lbic_top lbic_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .irq_out   (irq_out),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .mask_q    (mask_q),
  .hw_we     (hw_we),
  .hw_addr   (hw_addr),
  .hw_wdata  (hw_wdata)
);

// File: tb/lbic_top_tb.sv
module lbic_top_tb;
  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_req = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [31:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          irq_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] mdl_mask = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lbic_top #(.NUM_SRC(NS), .ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(input logic [15:0] p);
    for (int i = 0; i < 16; i++) if (p[i]) return 16'((i + 1) << 2);
    return 16'd0;
  endfunction

  function automatic logic [15:0] m_rd(input logic [11:0] a);
    if (a == 12'h000) return vec_of(irq_req & mdl_mask);
    if (a == 12'h002) return mdl_mask;
    return 16'd0;
  endfunction

  function automatic void m_wr(input logic [11:0] a, input logic [15:0] d);
    if (a == 12'h002) mdl_mask = d;
  endfunction

  // Reference model of one access; returns expected rsp_rdata
  function automatic logic [31:0] m_access(input logic wr, input logic [1:0] sz,
                                           input logic [31:0] addr, input logic [31:0] wd);
    logic [11:0] a0, a1;
    logic [15:0] h, lo, hi;
    a0 = {addr[11:1], 1'b0};
    a1 = a0 + 12'd2;
    if (sz == 2'd0) begin
      h = m_rd(a0);
      if (wr) begin
        h = addr[0] ? {wd[7:0], h[7:0]} : {h[15:8], wd[7:0]};
        m_wr(a0, h);
        return 32'd0;
      end
      return {24'd0, addr[0] ? h[15:8] : h[7:0]};
    end else if (sz == 2'd1) begin
      if (wr) begin m_wr(a0, wd[15:0]); return 32'd0; end
      return {16'd0, m_rd(a0)};
    end
    if (wr) begin
      m_wr(a0, wd[15:0]);
      m_wr(a1, wd[31:16]);
      return 32'd0;
    end
    lo = m_rd(a0);
    hi = m_rd(a1);
    return {hi, lo};
  endfunction

  task automatic bus(input logic wr, input logic [1:0] sz, input logic [31:0] addr,
                     input logic [31:0] wd, output logic [31:0] rd, output int lat,
                     output logic busy_ok);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = !req_ready;
    lat = 1;
    while (!rsp_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  // Run one access against the model and compare data and latency
  task automatic op(input string tag, input logic wr, input logic [1:0] sz,
                    input logic [31:0] addr, input logic [31:0] wd);
    logic [31:0] exp, rd;
    int lat;
    logic bz;
    exp = m_access(wr, sz, addr, wd);
    bus(wr, sz, addr, wd, rd, lat, bz);
    chk(tag, rd, exp);
    chk("R9 latency", 32'(lat), sz[1] ? 32'd3 : 32'd2);
    chk("R9 busy", {31'd0, bz}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_0421));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 irq_out", {31'd0, irq_out}, 32'd0);
    chk("R8 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R8 ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    op("R8 mask reads zero", 1'b0, 2'd1, 32'h002, 0);

    // R3 mask round trip
    op("R3 write", 1'b1, 2'd1, 32'h002, 32'h0000_A5C3);
    op("R3 readback", 1'b0, 2'd1, 32'h002, 0);
    op("R3 write ffff", 1'b1, 2'd1, 32'h002, 32'h0000_FFFF);

    // R2 vector corners
    irq_req = 16'h0000; op("R2 none pending", 1'b0, 2'd1, 32'h000, 0);
    irq_req = 16'h0001; op("R2 source0", 1'b0, 2'd1, 32'h000, 0);
    irq_req = 16'h8000; op("R2 source15", 1'b0, 2'd1, 32'h000, 0);
    irq_req = 16'h0088; op("R2 lowest of two", 1'b0, 2'd1, 32'h000, 0);
    op("R2 mask off bit3", 1'b1, 2'd1, 32'h002, 32'h0000_FF00);
    irq_req = 16'h0188; op("R2 masked lower", 1'b0, 2'd1, 32'h000, 0);

    // R1 output timing around a request change
    @(negedge clk);
    irq_req = 16'h0001;
    #1 chk("R1 before edge", {31'd0, irq_out}, 32'd1);
    @(negedge clk);
    chk("R1 after edge", {31'd0, irq_out}, 32'd0);
    irq_req = 16'h0200;
    @(negedge clk);
    chk("R1 enabled line", {31'd0, irq_out}, 32'd1);
    op("R1 mask clear", 1'b1, 2'd1, 32'h002, 0);
    chk("R1 after mask write", {31'd0, irq_out}, 32'd0);

    // R4/R5 byte lanes
    op("R5 low lane", 1'b1, 2'd0, 32'h002, 32'h0000_003C);
    op("R5 high lane", 1'b1, 2'd0, 32'h003, 32'h0000_00B1);
    op("R4 low byte", 1'b0, 2'd0, 32'h002, 0);
    op("R4 high byte", 1'b0, 2'd0, 32'h003, 0);
    op("R5 low lane keeps high", 1'b1, 2'd0, 32'h002, 32'hFFFF_FF07);
    op("R3 after byte merge", 1'b0, 2'd1, 32'h002, 0);

    // R6 word split and order
    irq_req = 16'h0004;
    op("R6 word write hi to mask", 1'b1, 2'd2, 32'h000, 32'h00FF_1234);
    op("R6 word read", 1'b0, 2'd2, 32'h000, 0);
    op("R6 word write at ffe wraps", 1'b1, 2'd3, 32'hFFE, 32'h5555_6666);
    op("R6 word read at ffe", 1'b0, 2'd3, 32'hFFE, 0);
    op("R6 word write low to mask", 1'b1, 2'd2, 32'h002, 32'h7777_0F0F);

    // R7 decode
    op("R7 unmapped read", 1'b0, 2'd1, 32'h004, 0);
    op("R7 unmapped write", 1'b1, 2'd1, 32'h006, 32'h0000_1111);
    op("R7 vector write ignored", 1'b1, 2'd1, 32'h000, 32'h0000_2222);
    op("R7 mask unchanged", 1'b0, 2'd1, 32'h002, 0);
    op("R7 high addr bits ignored", 1'b0, 2'd1, 32'hABCD_E002, 0);
    op("R7 bit0 ignored for half", 1'b0, 2'd1, 32'h003, 0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [11:0] offs [8];
      offs[0] = 12'h000; offs[1] = 12'h001; offs[2] = 12'h002; offs[3] = 12'h003;
      offs[4] = 12'h004; offs[5] = 12'h005; offs[6] = 12'hFFE; offs[7] = 12'hFFF;
      a = {$urandom() & 32'hFFFF_F000} | {20'd0, offs[$urandom_range(0, 7)]};
      @(negedge clk);
      irq_req = 16'($urandom());
      if ($urandom_range(0, 3) == 0) irq_req = 16'd0;
      op("R2/R6 random", 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), a, $urandom());
      chk("R1 random irq_out", {31'd0, irq_out}, {31'd0, |(irq_req & mdl_mask)});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule